// File: doc/BRIEF.md
# Strobed Two-Word Sequence Matcher

The block watches a wide parallel input bus. One bit of that bus acts as a validation strobe. A narrower data field, elsewhere on the same bus, carries the data word. Every bit the block uses passes through a synchronizer chain. When the synchronized strobe shows a rising edge, the data field is latched, and that latched word is the only thing the matcher ever looks at.

A two-state sequence detector compares each latched word against two host-programmed words. A match is the first word followed directly by the second. Each match raises a single-cycle pulse that advances a match counter. The counter wraps around when it overflows.

The host reaches both pattern words and the counter through a small register port. A write to the counter address clears the counter. The upper bits of the counter are mirrored on a set of status LEDs.

Top module: `strobe_pattern_matcher`

## Requirements
- R1: After a synchronous reset the counter, both pattern registers and the LED outputs read zero, and the detector starts in its idle state.
- R2: A data word is latched only on a rising edge of the synchronized strobe bit (bus bit STROBE_BIT); a strobe held high or a falling edge latches nothing. The data word is bus bits DATA_LSB upward, DATA_W wide.
- R3: In the idle state, a latched word equal to the first pattern arms the detector. In the armed state, a latched word equal to the second pattern raises a one-cycle match pulse that adds one to the counter and returns the detector to idle.
- R4: In the armed state, a latched word equal to the first pattern but not the second keeps the detector armed.
- R5: In the armed state, a latched word equal to neither pattern returns the detector to idle without counting.
- R6: The second-pattern test takes priority over the first-pattern test, so with both patterns equal, every second occurrence of that word counts. A second-pattern word seen while idle never counts.
- R7: The detector and counter change only on cycles that follow a latched word; changes on non-strobe bus bits without a strobe edge have no effect.
- R8: The register map uses reg_addr 0 for the first pattern and 1 for the second pattern. These registers keep the low DATA_W bits of reg_wdata, and read back zero-extended. Address 2 reads the counter zero-extended, and address 3 reads zero. Read data is registered and appears one cycle after the address.
- R9: Any write to address 2 clears the counter whatever the write data; a clear wins over a match in the same cycle.
- R10: The counter is CNT_W bits wide and wraps from its maximum value to zero.
- R11: The LED outputs show the counter's top LED_W bits, one cycle after the counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | BUS_W | Asynchronous input bus carrying strobe and data field |
| reg_we | input | 1 | Host register write enable |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | REG_W | Host write data |
| reg_rdata | output | REG_W | Registered host read data |
| leds | output | LED_W | Upper counter bits for status LEDs |

## Verification
The bench builds the block with the data field at bit 4, the strobe on bit 15 and a three-stage synchronizer. This checks that field placement and chain depth follow the parameters rather than the defaults. The counter is shrunk to 10 bits, so the LEDs show bits 9:2. With that width the wrap from 1023 to zero and a full LED byte can be reached with about a thousand matches. Random words drawn mostly from the two patterns, with noise on unused bus bits, exercise the arm, stay and drop paths of the detector.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } seq_state_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PAT_FIRST  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PAT_SECOND = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT      = 2'd2;
endpackage

// File: rtl/spm_strobe_capture.sv
module spm_strobe_capture #(
  parameter int BUS_W       = 16,
  parameter int DATA_W      = 8,
  parameter int DATA_LSB    = 0,
  parameter int STROBE_BIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int SW   = DATA_W + 1;
  localparam int LAST = SYNC_STAGES - 1;

  logic [SW-1:0] raw;
  logic [SYNC_STAGES-1:0][SW-1:0] sync_q;
  logic stb_prev_q;
  logic stb_now;
  logic rise;
  logic unused_bus;

  assign raw        = {bus_in[STROBE_BIT], bus_in[DATA_LSB +: DATA_W]};
  assign unused_bus = ^bus_in;

  // Synchronizer chain for the strobe and the data field together
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign stb_now = sync_q[LAST][DATA_W];
  assign rise    = stb_now & ~stb_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev_q   <= 1'b0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      stb_prev_q   <= stb_now;
      word_valid_o <= rise;
      if (rise) word_o <= sync_q[LAST][DATA_W-1:0];
    end
  end

  // R2: a strobe edge yields exactly one capture cycle
  assert_capture_once_R2: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  // R2: the latched word is only updated on a capture cycle
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !word_valid_o |-> $stable(word_o) || $past(rst));
endmodule

// File: rtl/spm_seq_fsm.sv
module spm_seq_fsm
  import spm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] pat_first_i,
  input  logic [DATA_W-1:0] pat_second_i,
  output logic              match_o
);
  seq_state_e state_q, state_d;
  logic       match_d;

  always_comb begin
    state_d = state_q;
    match_d = 1'b0;
    if (word_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (word_i == pat_first_i) state_d = ST_ARMED;
        end
        ST_ARMED: begin
          if (word_i == pat_second_i) begin
            match_d = 1'b1;
            state_d = ST_IDLE;
          end else if (word_i == pat_first_i) begin
            state_d = ST_ARMED;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      match_o <= 1'b0;
    end else begin
      state_q <= state_d;
      match_o <= match_d;
    end
  end

  // R3: match is a single-cycle pulse
  assert_match_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);

  // R3: a match only follows a captured word seen while armed
  assert_match_armed_R3: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(word_valid_i) && ($past(state_q) == ST_ARMED));

  // R7: without a captured word the state does not move
  assert_state_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !word_valid_i |=> $stable(state_q));
endmodule

// File: rtl/spm_match_counter.sv
module spm_match_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) count_o <= '0;
    else if (inc_i)   count_o <= count_o + 1'b1;
  end

  // R3/R10: an increment adds one, wrapping at the top
  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    $past(inc_i) && !$past(clr_i) |-> count_o == $past(count_o) + 1'b1);

  // R9: a clear always wins
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(clr_i) |-> count_o == '0);

  // R7: no increment and no clear leaves the count alone
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(inc_i) && !$past(clr_i) |-> $stable(count_o));
endmodule

// File: rtl/strobe_pattern_matcher.sv
module strobe_pattern_matcher
  import spm_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int DATA_W      = 8,
  parameter int DATA_LSB    = 0,
  parameter int STROBE_BIT  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16,
  parameter int LED_W       = 8,
  parameter int REG_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [LED_W-1:0]  leds
);
  localparam int LED_TOP = CNT_W - 1;

  logic [DATA_W-1:0] word;
  logic              word_valid;
  logic              match;
  logic              clr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] pat_first_q;
  logic [DATA_W-1:0] pat_second_q;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign clr          = reg_we && (reg_addr == ADDR_COUNT);

  spm_strobe_capture #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .DATA_LSB(DATA_LSB),
    .STROBE_BIT(STROBE_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_capture (
    .clk(clk), .rst(rst), .bus_in(bus_in),
    .word_o(word), .word_valid_o(word_valid)
  );

  spm_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .word_i(word), .word_valid_i(word_valid),
    .pat_first_i(pat_first_q), .pat_second_i(pat_second_q), .match_o(match)
  );

  spm_match_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .inc_i(match), .clr_i(clr), .count_o(count)
  );

  // Host pattern registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pat_first_q  <= '0;
      pat_second_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_PAT_FIRST)  pat_first_q  <= reg_wdata[DATA_W-1:0];
      if (reg_addr == ADDR_PAT_SECOND) pat_second_q <= reg_wdata[DATA_W-1:0];
    end
  end

  // Registered readout and LED mirror
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      leds      <= '0;
    end else begin
      leds <= count[LED_TOP -: LED_W];
      unique case (reg_addr)
        ADDR_PAT_FIRST:  reg_rdata <= REG_W'(pat_first_q);
        ADDR_PAT_SECOND: reg_rdata <= REG_W'(pat_second_q);
        ADDR_COUNT:      reg_rdata <= REG_W'(count);
        default:         reg_rdata <= '0;
      endcase
    end
  end

  // R8: a pattern write lands in the register on the next cycle
  assert_pat_write_R8: assert property (@(posedge clk) disable iff (rst)
    reg_we && (reg_addr == ADDR_PAT_FIRST) |=> pat_first_q == $past(reg_wdata[DATA_W-1:0]));

  // R11: LEDs follow the counter's top bits one cycle later
  assert_leds_track_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> leds == $past(count[LED_TOP -: LED_W]));
endmodule

// File: tb/strobe_pattern_matcher_tb_top.sv
module strobe_pattern_matcher_tb_top;
  localparam int BUS_W = 16, DATA_W = 8, DATA_LSB = 4, STROBE_BIT = 15;
  localparam int SYNC_STAGES = 3, CNT_W = 10, LED_W = 8, REG_W = 16;
  localparam logic [BUS_W-1:0] DATA_MASK  = BUS_W'({DATA_W{1'b1}}) << DATA_LSB;
  localparam logic [BUS_W-1:0] NOISE_MASK = ~(DATA_MASK | (BUS_W'(1) << STROBE_BIT));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BUS_W-1:0] bus_in = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic [LED_W-1:0] leds;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] m_p0 = '0, m_p1 = '0;
  bit m_armed = 1'b0;
  int m_count = 0;

  always #10 clk = ~clk;

  strobe_pattern_matcher #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .DATA_LSB(DATA_LSB), .STROBE_BIT(STROBE_BIT),
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .LED_W(LED_W), .REG_W(REG_W)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .leds(leds)
  );

  function automatic int model_wrap(input int c);
    return c % (1 << CNT_W);
  endfunction

  function automatic int model_leds(input int c);
    return (c >> (CNT_W - LED_W)) & ((1 << LED_W) - 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd0) m_p0 = d[DATA_W-1:0];
    if (a == 2'd1) m_p1 = d[DATA_W-1:0];
    if (a == 2'd2) m_count = 0;
  endtask

  task automatic read_reg(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic check_count(input string req);
    int v;
    read_reg(2'd2, v);
    check(req, v, m_count);
    check({req, " leds"}, int'(leds), model_leds(m_count));
  endtask

  // Model of R3..R6
  task automatic model_word(input logic [DATA_W-1:0] w);
    if (m_armed) begin
      if (w == m_p1) begin m_count = model_wrap(m_count + 1); m_armed = 1'b0; end
      else if (w != m_p0) m_armed = 1'b0;
    end else if (w == m_p0) begin
      m_armed = 1'b1;
    end
  endtask

  task automatic send_word(input logic [DATA_W-1:0] w, input logic [BUS_W-1:0] noise);
    bus_in = noise & NOISE_MASK;
    bus_in[DATA_LSB +: DATA_W] = w;
    repeat (3) @(negedge clk);
    bus_in[STROBE_BIT] = 1'b1;
    repeat (3) @(negedge clk);
    bus_in[STROBE_BIT] = 1'b0;
    repeat (3) @(negedge clk);
    model_word(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_count("R1 count");
    read_reg(2'd0, v); check("R1 first pattern", v, 0);
    read_reg(2'd1, v); check("R1 second pattern", v, 0);

    // R8 register map
    write_reg(2'd0, 16'hAB3C);
    write_reg(2'd1, 16'h12A5);
    read_reg(2'd0, v); check("R8 first pattern readback", v, 16'h003C);
    read_reg(2'd1, v); check("R8 second pattern readback", v, 16'h00A5);
    read_reg(2'd3, v); check("R8 spare address", v, 0);

    // R3 basic match
    send_word(8'h3C, 16'h0);
    send_word(8'hA5, 16'h0);
    check_count("R3 basic match");

    // R4 repeated first word stays armed
    send_word(8'h3C, 16'h0); send_word(8'h3C, 16'h0); send_word(8'hA5, 16'h0);
    check_count("R4 repeat first");
    check("R4 expected count", m_count, 2);

    // R5 other word drops
    send_word(8'h3C, 16'h0); send_word(8'h55, 16'h0); send_word(8'hA5, 16'h0);
    check_count("R5 drop to idle");

    // R6 second word while idle
    send_word(8'hA5, 16'h0); send_word(8'hA5, 16'h0);
    check_count("R6 second word idle");

    // R7 noise without strobe edge; R2 held strobe and falling edge
    send_word(8'h01, 16'h0);
    bus_in = NOISE_MASK;
    bus_in[DATA_LSB +: DATA_W] = 8'h3C;
    repeat (8) @(negedge clk);
    send_word(8'hA5, 16'h0);
    check_count("R7 noise ignored");
    bus_in = '0; bus_in[DATA_LSB +: DATA_W] = 8'h3C;
    repeat (3) @(negedge clk);
    bus_in[STROBE_BIT] = 1'b1;
    repeat (4) @(negedge clk);
    model_word(8'h3C);
    bus_in[DATA_LSB +: DATA_W] = 8'hA5;
    repeat (6) @(negedge clk);
    check_count("R2 held strobe");
    bus_in[STROBE_BIT] = 1'b0;
    repeat (6) @(negedge clk);
    check_count("R2 falling edge");
    send_word(8'hA5, 16'h0);
    check_count("R2 still armed after held strobe");

    // R9 clear with arbitrary data
    write_reg(2'd2, 16'hFFFF);
    check_count("R9 clear");
    check("R9 expected zero", m_count, 0);

    // R6 equal patterns
    write_reg(2'd0, 16'h0077);
    write_reg(2'd1, 16'h0077);
    m_armed = 1'b0;
    send_word(8'h01, 16'h0);
    for (int i = 0; i < 5; i++) send_word(8'h77, 16'h0);
    check_count("R6 equal patterns");
    check("R6 expected", m_count, 2);

    // Random mixed stream
    write_reg(2'd0, 16'h003C);
    write_reg(2'd1, 16'h00A5);
    send_word(8'h01, 16'h0);
    for (int i = 0; i < 240; i++) begin
      logic [DATA_W-1:0] w;
      int r;
      r = int'($urandom % 5);
      w = (r < 2) ? 8'h3C : (r < 4) ? 8'hA5 : DATA_W'($urandom);
      send_word(w, BUS_W'($urandom));
      if (i % 12 == 11) check_count("R3 R4 R5 random stream");
    end

    // R10 wrap and R11 full LED value
    write_reg(2'd0, 16'h0011);
    write_reg(2'd1, 16'h0022);
    send_word(8'h01, 16'h0);
    write_reg(2'd2, 16'h0);
    for (int i = 0; i < (1 << CNT_W) - 1; i++) begin
      send_word(8'h11, 16'h0);
      send_word(8'h22, 16'h0);
    end
    check_count("R11 counter at maximum");
    check("R11 leds all set", int'(leds), (1 << LED_W) - 1);
    send_word(8'h11, 16'h0);
    send_word(8'h22, 16'h0);
    check_count("R10 wrap to zero");

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule